// File: doc/BRIEF.md
# Address-Range Cache Maintenance Sequencer

This block turns one request for cache maintenance over a physical address range into an ordered stream of commands for a cache controller. A request carries a start address, an end address (exclusive) and an operation: invalidate, clean, or clean-and-invalidate. The sequencer emits one command per cache line on a valid/ready command port. It finishes with a single sync command, and a one-cycle done pulse follows once the sync has been taken.

Invalidating a line that the range only partly covers would throw away bytes that belong to someone else. When an invalidate request has an unaligned boundary, the line at that boundary is therefore cleaned and invalidated rather than just invalidated. A clean or clean-and-invalidate request whose span reaches the cache capacity becomes one whole-cache command. The sequencer issues work only while it holds an arbitration grant. It gives the grant back between fixed-size blocks of lines so that other requesters can get in.

The line commands themselves are carried out elsewhere. A busy input from the executor tells the sequencer when outstanding line work has drained.

Top module: `range_maint_seq`

## Requirements
- R1: Every line command carries the line address, which is the byte address with its low log2(LINE_BYTES) bits cleared. Way and sync commands carry address 0.
- R2: For invalidate (req_op 0) with an unaligned start, the first command is a clean-and-invalidate (cmd_kind 2) of the start line. Plain invalidates then begin one line above it.
- R3: For invalidate with an unaligned end, a clean-and-invalidate of the line holding the end follows any start-edge command. Plain invalidates (cmd_kind 0) stop below that line. If start and end fall inside the same line, that line is cleaned and invalidated twice and no plain invalidate is issued.
- R4: For clean (req_op 1) and clean-and-invalidate (req_op 2 or 3), the start is rounded down to a line boundary. Lines are then issued in ascending order while the line address is below the end, using cmd_kind 1 for clean and cmd_kind 2 for clean-and-invalidate.
- R5: For clean or clean-and-invalidate, when end minus start is at least CACHE_BYTES, exactly one whole-cache command is issued instead of any line commands: cmd_kind 3 for clean, cmd_kind 4 for clean-and-invalidate. Invalidate never takes this path.
- R6: At most BLOCK_BYTES/LINE_BYTES line commands are issued between yields. A one-cycle yield_req pulse appears after a full block only when more lines remain. Issuing resumes only after grant is seen high.
- R7: No command is presented after a request is accepted until grant is high.
- R8: The last command of every request is a single sync (cmd_kind 5). It is presented only after line_busy has been seen low following the previous command.
- R9: A request whose start equals its end at a line-aligned address produces only the sync command.
- R10: done pulses for exactly one cycle, in the cycle after the sync is accepted. req_ready is high only while idle, and no command or yield is presented in that state.
- R11: Once cmd_valid is raised, cmd_valid, cmd_kind and cmd_addr hold steady until cmd_ready is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Address one past the last byte of the range |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 or 3 clean-and-invalidate |
| grant | input | 1 | Arbitration grant held by this requester |
| yield_req | output | 1 | One-cycle pulse releasing the grant between blocks |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted when high with cmd_valid |
| cmd_kind | output | 3 | 0 line inv, 1 line clean, 2 line clean+inv, 3 whole clean, 4 whole clean+inv, 5 sync |
| cmd_addr | output | ADDR_W | Line address for line commands, else 0 |
| line_busy | input | 1 | Executor still working on issued commands |
| done | output | 1 | One-cycle pulse after the sync is accepted |

## Verification
The bench builds the sequencer with 32-byte lines, 128-byte blocks and a 1 KB cache. With these values, a range of a few hundred bytes crosses several block boundaries, and a 1 KB range reaches the whole-cache threshold. Yield, re-grant and fallback paths therefore show up in short runs. Under these settings a full-capacity invalidate walks 32 lines with seven yields between them. Combined with backpressure on the command port and a busy executor, this exercises every ordering rule within a few hundred cycles per case.

// File: rtl/rms_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the range maintenance sequencer.
// Assumes: req_op and cmd_kind codes are fixed by the brief and decoded by neighbours.
package rms_pkg;
    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_CLINV = 2'd2,
        OP_ALT   = 2'd3
    } maint_op_e;

    typedef enum logic [2:0] {
        CK_LINE_INV   = 3'd0,
        CK_LINE_CLEAN = 3'd1,
        CK_LINE_CLINV = 3'd2,
        CK_WAY_CLEAN  = 3'd3,
        CK_WAY_CLINV  = 3'd4,
        CK_SYNC       = 3'd5
    } cmd_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ACQ,
        S_EDGE_LO,
        S_EDGE_HI,
        S_LINES,
        S_YIELD,
        S_REACQ,
        S_WAY,
        S_DRAIN,
        S_SYNC
    } seq_state_e;
endpackage

// File: rtl/rms_range_plan.sv
`timescale 1ns/1ps
// Range planner: combinational decode of a latched request into edge lines,
// the interior walk window, the whole-cache decision and the command kinds.
// Assumes: end_addr >= start_addr, LINE_BYTES is a power of two >= 2.
module rms_range_plan #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CACHE_BYTES = 262144
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [1:0]        op,
    output logic [ADDR_W-1:0] start_line,
    output logic [ADDR_W-1:0] end_line,
    output logic              edge_lo,
    output logic              edge_hi,
    output logic [ADDR_W-1:0] walk_first,
    output logic [ADDR_W-1:0] walk_limit,
    output logic              walk_any,
    output logic              whole_op,
    output logic [2:0]        line_kind,
    output logic [2:0]        way_kind
);
    import rms_pkg::*;

    localparam int                OFS_W      = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_STEP  = ADDR_W'(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK  = ~(LINE_STEP - 1'b1);
    localparam logic [ADDR_W:0]   CACHE_SPAN = (ADDR_W+1)'(CACHE_BYTES);

    maint_op_e         op_e;
    logic              is_inv;
    logic              is_clean;
    logic [ADDR_W:0]   span;

    // Decode the operation code.
    always_comb begin
        op_e     = maint_op_e'(op);
        is_inv   = (op_e == OP_INV);
        is_clean = (op_e == OP_CLEAN);
    end

    // Line-align both boundaries and flag partial lines of an invalidate.
    always_comb begin
        start_line = start_addr & LINE_MASK;
        end_line   = end_addr & LINE_MASK;
        edge_lo    = is_inv && (start_addr[OFS_W-1:0] != '0);
        edge_hi    = is_inv && (end_addr[OFS_W-1:0] != '0);
    end

    // Interior walk window: skips partial edges of an invalidate.
    always_comb begin
        walk_first = edge_lo ? (start_line + LINE_STEP) : start_line;
        walk_limit = edge_hi ? end_line : end_addr;
        walk_any   = (walk_first < walk_limit);
    end

    // Whole-cache fallback for write-back operations and command kinds.
    always_comb begin
        span      = {1'b0, end_addr} - {1'b0, start_addr};
        whole_op  = !is_inv && (span >= CACHE_SPAN);
        line_kind = is_inv ? CK_LINE_INV : (is_clean ? CK_LINE_CLEAN : CK_LINE_CLINV);
        way_kind  = is_clean ? CK_WAY_CLEAN : CK_WAY_CLINV;
    end
endmodule

// File: rtl/rms_line_walker.sv
`timescale 1ns/1ps
// Line walker: holds the current line address and the walk limit,
// steps by one line per accepted line command and flags the last line.
// Assumes: load and advance are never high together.
module rms_line_walker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] first,
    input  logic [ADDR_W-1:0] limit,
    output logic [ADDR_W-1:0] cur,
    output logic              last
);
    localparam logic [ADDR_W:0] LINE_STEP_W = (ADDR_W+1)'(LINE_BYTES);

    logic [ADDR_W-1:0] limit_q;
    logic [ADDR_W:0]   next_wide;

    // Register the current line and the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= '0;
            limit_q <= '0;
        end else if (load) begin
            cur     <= first;
            limit_q <= limit;
        end else if (advance) begin
            cur     <= next_wide[ADDR_W-1:0];
        end
    end

    // The current line is the last one when the next would reach the limit.
    always_comb begin
        next_wide = {1'b0, cur} + LINE_STEP_W;
        last      = (next_wide >= {1'b0, limit_q});
    end
endmodule

// File: rtl/rms_blk_pacer.sv
`timescale 1ns/1ps
// Block pacer: counts line commands within a block and flags the one
// that fills it, so the sequencer can yield before the next block.
// Assumes: clear and step are never high together.
module rms_blk_pacer #(
    parameter int LINES_PER_BLK = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic blk_full
);
    localparam int             CNT_W    = $clog2(LINES_PER_BLK + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LINES_PER_BLK - 1);

    logic [CNT_W-1:0] cnt;

    // Count lines in the block, wrapping when it fills.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= blk_full ? '0 : cnt + 1'b1;
        end
    end

    // The line now being issued closes the block.
    assign blk_full = (cnt == LAST_IDX);
endmodule

// File: rtl/range_maint_seq.sv
`timescale 1ns/1ps
// Address-range cache maintenance sequencer (top).
// Accepts a range and an operation, then emits edge, interior or whole-cache
// commands, yields between blocks, drains and ends with a sync.
// Assumes: req_end >= req_start; the grant is held until yield_req is pulsed.
module range_maint_seq #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int BLOCK_BYTES = 4096,
    parameter int CACHE_BYTES = 262144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic [1:0]        req_op,
    input  logic              grant,
    output logic              yield_req,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [2:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              line_busy,
    output logic              done
);
    import rms_pkg::*;

    localparam int LINES_PER_BLK = BLOCK_BYTES / LINE_BYTES;

    seq_state_e        state, state_nx;
    logic [ADDR_W-1:0] start_q, end_q;
    logic [1:0]        op_q;
    logic              done_q;

    logic [ADDR_W-1:0] start_line, end_line, walk_first, walk_limit, cur;
    logic              edge_lo, edge_hi, walk_any, whole_op, walk_last, blk_full;
    logic [2:0]        line_kind, way_kind;
    logic              walk_load, walk_step;

    rms_range_plan #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CACHE_BYTES(CACHE_BYTES)
    ) u_plan (
        .start_addr(start_q), .end_addr(end_q), .op(op_q),
        .start_line(start_line), .end_line(end_line),
        .edge_lo(edge_lo), .edge_hi(edge_hi),
        .walk_first(walk_first), .walk_limit(walk_limit), .walk_any(walk_any),
        .whole_op(whole_op), .line_kind(line_kind), .way_kind(way_kind)
    );

    rms_line_walker #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .load(walk_load), .advance(walk_step),
        .first(walk_first), .limit(walk_limit), .cur(cur), .last(walk_last)
    );

    rms_blk_pacer #(
        .LINES_PER_BLK(LINES_PER_BLK)
    ) u_pace (
        .clk(clk), .rst_n(rst_n), .clear(walk_load), .step(walk_step),
        .blk_full(blk_full)
    );

    // Walker and pacer controls.
    assign walk_load = (state == S_ACQ) && grant;
    assign walk_step = (state == S_LINES) && cmd_ready;

    // Next-state selection for the command sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nx = S_ACQ;
            S_ACQ:     if (grant) begin
                           if (whole_op)      state_nx = S_WAY;
                           else if (edge_lo)  state_nx = S_EDGE_LO;
                           else if (edge_hi)  state_nx = S_EDGE_HI;
                           else if (walk_any) state_nx = S_LINES;
                           else               state_nx = S_DRAIN;
                       end
            S_EDGE_LO: if (cmd_ready) begin
                           if (edge_hi)       state_nx = S_EDGE_HI;
                           else if (walk_any) state_nx = S_LINES;
                           else               state_nx = S_DRAIN;
                       end
            S_EDGE_HI: if (cmd_ready) state_nx = walk_any ? S_LINES : S_DRAIN;
            S_LINES:   if (cmd_ready) begin
                           if (walk_last)     state_nx = S_DRAIN;
                           else if (blk_full) state_nx = S_YIELD;
                       end
            S_YIELD:   state_nx = S_REACQ;
            S_REACQ:   if (grant) state_nx = S_LINES;
            S_WAY:     if (cmd_ready) state_nx = S_DRAIN;
            S_DRAIN:   if (!line_busy) state_nx = S_SYNC;
            S_SYNC:    if (cmd_ready) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // State, request capture and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            start_q <= '0;
            end_q   <= '0;
            op_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= (state == S_SYNC) && cmd_ready;
            if (state == S_IDLE && req_valid) begin
                start_q <= req_start;
                end_q   <= req_end;
                op_q    <= req_op;
            end
        end
    end

    // Command port outputs decoded from the state.
    always_comb begin
        cmd_valid = 1'b1;
        cmd_kind  = CK_SYNC;
        cmd_addr  = '0;
        unique case (state)
            S_EDGE_LO: begin cmd_kind = CK_LINE_CLINV; cmd_addr = start_line; end
            S_EDGE_HI: begin cmd_kind = CK_LINE_CLINV; cmd_addr = end_line;   end
            S_LINES:   begin cmd_kind = line_kind;     cmd_addr = cur;        end
            S_WAY:     cmd_kind = way_kind;
            S_SYNC:    cmd_kind = CK_SYNC;
            default:   cmd_valid = 1'b0;
        endcase
    end

    assign req_ready = (state == S_IDLE);
    assign yield_req = (state == S_YIELD);
    assign done      = done_q;
endmodule

// File: rtl/range_maint_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for range_maint_seq, attached by bind.
// Assumes: line_busy rises only in response to accepted commands.
module range_maint_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              yield_req,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_kind,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              line_busy,
    input logic              done
);
    // R11
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_addr)));

    // R8
    sync_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd5 && !$past(cmd_valid && cmd_kind == 3'd5)) |-> $past(!line_busy));

    // R10
    done_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid && cmd_ready && cmd_kind == 3'd5));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !yield_req));

    // R6
    yield_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        yield_req |=> (!yield_req && !cmd_valid));
endmodule

bind range_maint_seq range_maint_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .yield_req(yield_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .line_busy(line_busy), .done(done)
);

// File: tb/tb_range_maint_seq.sv
`timescale 1ns/1ps
// Directed bench for range_maint_seq: one task per scenario, each comparing
// the observed command log against a reference list built from the brief.
module tb_range_maint_seq;
    localparam int ADDR_W = 32;
    localparam int LINE_B = 32;
    localparam int BLK_B  = 128;
    localparam int CACHE_B = 1024;
    localparam int LPB    = BLK_B / LINE_B;
    localparam int MAXLOG = 512;
    localparam logic [2:0] YIELD_MARK = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_start = '0;
    logic [ADDR_W-1:0] req_end = '0;
    logic [1:0] req_op = '0;
    logic grant = 1'b1;
    logic yield_req;
    logic cmd_valid;
    logic cmd_ready = 1'b0;
    logic [2:0] cmd_kind;
    logic [ADDR_W-1:0] cmd_addr;
    logic line_busy = 1'b0;
    logic done;

    range_maint_seq #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_B), .BLOCK_BYTES(BLK_B), .CACHE_BYTES(CACHE_B)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_end(req_end), .req_op(req_op), .grant(grant),
        .yield_req(yield_req), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .line_busy(line_busy), .done(done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [2:0]        log_kind [MAXLOG];
    logic [ADDR_W-1:0] log_addr [MAXLOG];
    int log_n = 0;
    logic [2:0]        exp_kind [MAXLOG];
    logic [ADDR_W-1:0] exp_addr [MAXLOG];
    int exp_n = 0;
    int done_cnt = 0, early_done = 0, sync_bad = 0, grant_bad = 0;
    int busy_cnt = 0, gdrop = 0;
    bit sync_seen = 1'b0, bp_mode = 1'b0, bp_tog = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Command sink, executor busy model and arbiter, all at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bp_tog = ~bp_tog;
            cmd_ready = bp_mode ? bp_tog : 1'b1;
            if (busy_cnt != 0) busy_cnt--;
            if (cmd_valid && cmd_ready) begin
                if (!grant) grant_bad++;
                if (cmd_kind == 3'd5) begin
                    if (line_busy) sync_bad++;
                    sync_seen = 1'b1;
                end else begin
                    busy_cnt = 3;
                end
                if (log_n < MAXLOG) begin
                    log_kind[log_n] = cmd_kind;
                    log_addr[log_n] = cmd_addr;
                end
                log_n++;
            end
            line_busy = (busy_cnt != 0);
            if (yield_req) begin
                if (log_n < MAXLOG) begin
                    log_kind[log_n] = YIELD_MARK;
                    log_addr[log_n] = '0;
                end
                log_n++;
                grant = 1'b0;
                gdrop = 3;
            end else if (gdrop > 0) begin
                gdrop--;
                if (gdrop == 0) grant = 1'b1;
            end
            if (done) begin
                done_cnt++;
                if (!sync_seen) early_done++;
            end
        end
    end

    task automatic push_exp(input logic [2:0] k, input longint unsigned a);
        if (exp_n < MAXLOG) begin
            exp_kind[exp_n] = k;
            exp_addr[exp_n] = a[ADDR_W-1:0];
        end
        exp_n++;
    endtask

    // Reference sequence built from the requirements.
    task automatic build_exp(input longint unsigned s_in, input longint unsigned e_in,
                             input logic [1:0] op);
        longint unsigned s = s_in, e = e_in, lm = LINE_B - 1;
        logic [2:0] k;
        int cnt = 0;
        exp_n = 0;
        if (op != 2'd0 && (e - s) >= CACHE_B) begin
            push_exp((op == 2'd1) ? 3'd3 : 3'd4, 0);
            push_exp(3'd5, 0);
            return;
        end
        if (op == 2'd0) begin
            if ((s & lm) != 0) begin
                push_exp(3'd2, s & ~lm);
                s = (s & ~lm) + LINE_B;
            end
            if ((e & lm) != 0) begin
                e = e & ~lm;
                push_exp(3'd2, e);
            end
            k = 3'd0;
        end else begin
            s = s & ~lm;
            k = (op == 2'd1) ? 3'd1 : 3'd2;
        end
        while (s < e) begin
            push_exp(k, s);
            s += LINE_B;
            cnt++;
            if (cnt == LPB && s < e) begin
                push_exp(YIELD_MARK, 0);
                cnt = 0;
            end
        end
        push_exp(3'd5, 0);
    endtask

    task automatic clear_log();
        log_n = 0; done_cnt = 0; early_done = 0; sync_bad = 0; grant_bad = 0;
        sync_seen = 1'b0;
    endtask

    task automatic issue(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] e,
                         input logic [1:0] op);
        @(negedge clk); #1;
        req_start = s; req_end = e; req_op = op; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && done_cnt == 0; i++) begin
            @(negedge clk); #1;
        end
        repeat (3) begin @(negedge clk); #1; end
    endtask

    // Compare the log with the reference and the per-request protocol counters.
    task automatic compare(input string req);
        int bad = -1;
        check(log_n == exp_n, req, "command count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n && i < MAXLOG; i++) begin
            if (bad < 0 && (log_kind[i] != exp_kind[i] || log_addr[i] != exp_addr[i])) bad = i;
        end
        if (bad >= 0)
            check(1'b0, req, $sformatf("entry %0d kind/addr", bad),
                  {log_kind[bad], log_addr[bad]}, {exp_kind[bad], exp_addr[bad]});
        else
            check(1'b1, req, "sequence", 0, 0);
        // R10 one done pulse, after the sync
        check(done_cnt == 1 && early_done == 0, "R10", "done pulses", done_cnt, 1);
        // R8 sync only with executor idle
        check(sync_bad == 0, "R8", "sync while busy", sync_bad, 0);
        // R6 nothing accepted without grant
        check(grant_bad == 0, "R6", "command without grant", grant_bad, 0);
    endtask

    task automatic run_case(input string req, input logic [ADDR_W-1:0] s,
                            input logic [ADDR_W-1:0] e, input logic [1:0] op);
        clear_log();
        build_exp(s, e, op);
        issue(s, e, op);
        wait_done();
        compare(req);
    endtask

    task automatic t_reset();
        // R10 idle state after reset
        check(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);
        check(cmd_valid == 1'b0 && yield_req == 1'b0 && done == 1'b0, "R10",
              "outputs quiet after reset", {cmd_valid, yield_req, done}, 0);
    endtask

    task automatic t_inv_aligned();   run_case("R1 R4", 32'h1000, 32'h1060, 2'd0); endtask
    task automatic t_inv_edges();     run_case("R2 R3", 32'h2004, 32'h20F0, 2'd0); endtask
    task automatic t_inv_same_line(); run_case("R3", 32'h6008, 32'h6008, 2'd0); endtask
    task automatic t_clean_round();   run_case("R4 R1", 32'h3011, 32'h3050, 2'd1); endtask
    task automatic t_whole_clean();   run_case("R5", 32'h0000, 32'h0400, 2'd1); endtask
    task automatic t_whole_clinv();   run_case("R5", 32'h0100, 32'h0600, 2'd2); endtask
    task automatic t_inv_large();     run_case("R5 R6", 32'h0000, 32'h0400, 2'd0); endtask
    task automatic t_empty();         run_case("R9", 32'h5000, 32'h5000, 2'd1); endtask

    task automatic t_blocks_backpressure();
        bp_mode = 1'b1;
        run_case("R6 R11", 32'h4000, 32'h4200, 2'd3);
        bp_mode = 1'b0;
    endtask

    task automatic t_grant_hold();
        int early = 0;
        @(negedge clk); #1;
        grant = 1'b0; gdrop = 0;
        clear_log();
        build_exp(32'h7000, 32'h7040, 2'd2);
        issue(32'h7000, 32'h7040, 2'd2);
        repeat (10) begin
            @(negedge clk); #1;
            if (cmd_valid) early++;
        end
        // R7 nothing presented before grant
        check(early == 0 && log_n == 0, "R7", "commands before grant", early + log_n, 0);
        grant = 1'b1;
        wait_done();
        compare("R7");
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_inv_aligned();
        t_inv_edges();
        t_inv_same_line();
        t_clean_round();
        t_whole_clean();
        t_whole_clinv();
        t_inv_large();
        t_empty();
        t_blocks_backpressure();
        t_grant_hold();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule